// File: doc/BRIEF.md
# Per-Pin GPIO Sense and Interrupt Port

This block is one 8-pin slice of a digital I/O port. Each pin has its own control register on a simple register bus. That register holds four settings: an inversion bit that acts on both the input path and the output path, a stored threshold-type bit, a stored pull-up bit, and a 3-bit input/sense mode. An output-value register and a direction register drive the pad output and its output enable. The pad output passes through the pin's inversion on the way out.

Each pad input passes through a two-flip-flop synchronizer and then through the pin's inversion. The result feeds the input-value register and a detector. The input-value bit follows the pin only while its digital input is enabled. In the input-disabled mode the bit holds its last value. The detector watches for the configured condition and sets a per-pin flag. The condition is both edges, rising edges, falling edges or a low level, all judged on the inverted value. Software clears a flag by writing 1 to it. The combined interrupt output is high while any flag is set. The threshold and pull-up bits are not used inside the block. They leave the block as static per-pin controls.

Top module: `gpio_sense_port`

## Requirements
- R1: After reset every register reads 0x00. `pad_oe`, `pad_out`, `pull_en`, `ttl_sel` and `irq` are all 0.
- R2: The register map is as follows. 0x00 is the output value and 0x01 is the direction (1 = drive). 0x02 is the input value, which is read-only. 0x03 holds the interrupt flags. 0x10+n is the control register of pin n. In a control register, bit 7 = invert, bit 6 = threshold select, bit 3 = pull-up enable and bits 2:0 = sense mode. Bits 5:4 always read 0.
- R3: `pad_out[n]` equals output-value bit n XOR invert bit n. `pad_oe` equals the direction register. `pull_en[n]` and `ttl_sel[n]` equal bit 3 and bit 6 of control register n.
- R4: While pin n's input is enabled, input-value bit n equals the pad level XOR invert bit n. It is readable from the third rising clock edge after the pad changes.
- R5: Sense mode 1 sets flag n on any change of the inverted input. Mode 2 sets it on a 0-to-1 change and mode 3 on a 1-to-0 change. Mode 5 sets it whenever the inverted input is 0.
- R6: Sense modes 0, 6 and 7 never set flag n, and the input-value bit still follows the pin.
- R7: Sense mode 4 never sets flag n, and input-value bit n keeps its last value while the pad changes.
- R8: A pad change made while pin n is in mode 4 produces no flag when the pin is later switched to an edge mode.
- R9: In mode 5, while the inverted input is 0, writing 1 to flag n leaves it set.
- R10: Writing 1 to bit n of 0x03 clears flag n, and writing 0 leaves it unchanged. A detection in the same cycle as the clear wins. `irq` is high exactly when some flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels after inversion |
| pad_oe | output | 8 | Pad output enables |
| pull_en | output | 8 | Per-pin pull-up enable |
| ttl_sel | output | 8 | Per-pin threshold type select |
| irq | output | 1 | Combined interrupt request |

## Verification
Some rules are checked by assertions on every cycle, inside each pin:
- The input-value bit holds while the input is disabled.
- A low inverted input in level mode leaves the flag set on the next cycle.
- A flag never rises in a mode that has no interrupt.
- A clear with no detection in the same cycle drops the flag.

Other behaviour only the bench scenarios can show:
- The pipeline latency from pad to register.
- The edge types seen when inversion is on.
- The absence of a false edge when a pin is re-enabled.
- The partial write-1-to-clear behaviour.
- The output inversion.

These scenarios mix random modes and pad patterns with directed cases.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned REG_W = 8;

    localparam logic [2:0] SENSE_OFF  = 3'd0;
    localparam logic [2:0] SENSE_BOTH = 3'd1;
    localparam logic [2:0] SENSE_RISE = 3'd2;
    localparam logic [2:0] SENSE_FALL = 3'd3;
    localparam logic [2:0] SENSE_NOIN = 3'd4;
    localparam logic [2:0] SENSE_LOW  = 3'd5;

    localparam int unsigned BIT_INV  = 7;
    localparam int unsigned BIT_TTL  = 6;
    localparam int unsigned BIT_PULL = 3;

    typedef struct packed {
        logic       inven;
        logic       ttl;
        logic       pull;
        logic [2:0] sense;
        logic       hist;
        logic       inval;
        logic       flag;
    } pin_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stage1 = async_in;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stage2;
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             flag_clr,
    input  logic             sync_in,
    output logic [REG_W-1:0] ctrl_rd,
    output logic             inven,
    output logic             in_val,
    output logic             flag
);
    pin_state_t s_d, s_q;
    logic inv_in;
    logic in_en;
    logic int_en;
    logic rise;
    logic fall;
    logic detect;

    always_comb begin
        s_d    = s_q;
        inv_in = sync_in ^ s_q.inven;
        in_en  = (s_q.sense != SENSE_NOIN);
        rise   = inv_in & ~s_q.hist;
        fall   = ~inv_in & s_q.hist;
        int_en = 1'b0;
        detect = 1'b0;
        case (s_q.sense)
            SENSE_BOTH: begin int_en = 1'b1; detect = rise | fall; end
            SENSE_RISE: begin int_en = 1'b1; detect = rise; end
            SENSE_FALL: begin int_en = 1'b1; detect = fall; end
            SENSE_LOW:  begin int_en = 1'b1; detect = ~inv_in; end
            default:    begin int_en = 1'b0; detect = 1'b0; end
        endcase
        // history follows the pin in every mode, so it is fresh on re-enable
        s_d.hist = inv_in;
        if (in_en) s_d.inval = inv_in;
        s_d.flag = (s_q.flag & ~flag_clr) | detect;
        if (ctrl_wr) begin
            s_d.inven = ctrl_wdata[BIT_INV];
            s_d.ttl   = ctrl_wdata[BIT_TTL];
            s_d.pull  = ctrl_wdata[BIT_PULL];
            s_d.sense = ctrl_wdata[2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[BIT_INV]  = s_q.inven;
        ctrl_rd[BIT_TTL]  = s_q.ttl;
        ctrl_rd[BIT_PULL] = s_q.pull;
        ctrl_rd[2:0]      = s_q.sense;
    end

    assign inven  = s_q.inven;
    assign in_val = s_q.inval;
    assign flag   = s_q.flag;

    assert_in_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_en) |=> (s_q.inval == $past(s_q.inval)));

    assert_level_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sense == SENSE_LOW && !inv_in) |=> s_q.flag);

    assert_no_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en) |=> !(s_q.flag && !$past(s_q.flag)));

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !detect) |=> !s_q.flag);
endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
    import gpio_pkg::*;
#(
    parameter int unsigned N_PINS    = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CTRL_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pull_en,
    output logic [N_PINS-1:0] ttl_sel,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(3);

    typedef struct packed {
        logic [N_PINS-1:0] outv;
        logic [N_PINS-1:0] dir;
    } port_state_t;

    port_state_t s_d, s_q;
    logic [N_PINS-1:0] sync_val;
    logic [N_PINS-1:0] inv_vec;
    logic [N_PINS-1:0] in_vec;
    logic [N_PINS-1:0] flag_vec;
    logic [N_PINS-1:0] clr_vec;
    logic [N_PINS-1:0] ctrl_wr_vec;
    logic [REG_W-1:0]  ctrl_rd [N_PINS];

    gpio_sync #(.WIDTH(N_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_val)
    );

    always_comb begin
        s_d = s_q;
        if (bus_wr && bus_addr == A_OUT) s_d.outv = bus_wdata[N_PINS-1:0];
        if (bus_wr && bus_addr == A_DIR) s_d.dir  = bus_wdata[N_PINS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clr_vec = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[N_PINS-1:0] : '0;

    for (genvar n = 0; n < N_PINS; n++) begin : g_pin
        assign ctrl_wr_vec[n] = bus_wr && (bus_addr == ADDR_W'(CTRL_BASE + n));
        gpio_pin u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_wr    (ctrl_wr_vec[n]),
            .ctrl_wdata (bus_wdata),
            .flag_clr   (clr_vec[n]),
            .sync_in    (sync_val[n]),
            .ctrl_rd    (ctrl_rd[n]),
            .inven      (inv_vec[n]),
            .in_val     (in_vec[n]),
            .flag       (flag_vec[n])
        );
        assign pull_en[n] = ctrl_rd[n][BIT_PULL];
        assign ttl_sel[n] = ctrl_rd[n][BIT_TTL];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_OUT:   bus_rdata[N_PINS-1:0] = s_q.outv;
            A_DIR:   bus_rdata[N_PINS-1:0] = s_q.dir;
            A_IN:    bus_rdata[N_PINS-1:0] = in_vec;
            A_FLAG:  bus_rdata[N_PINS-1:0] = flag_vec;
            default: begin
                for (int n = 0; n < N_PINS; n++)
                    if (bus_addr == ADDR_W'(CTRL_BASE + n)) bus_rdata = ctrl_rd[n];
            end
        endcase
    end

    assign pad_out = s_q.outv ^ inv_vec;
    assign pad_oe  = s_q.dir;
    assign irq     = |flag_vec;

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($countones(flag_vec) > 0));
endmodule

// File: tb/tb_gpio_sense_port.sv
`timescale 1ns/1ps
module tb_gpio_sense_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pull_en, ttl_sel;
    logic       irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    gpio_sense_port dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
        .ttl_sel(ttl_sel), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    function automatic logic exp_flag(input logic [2:0] m, input logic a, input logic b);
        case (m)
            3'd1: return a != b;
            3'd2: return !a && b;
            3'd3: return a && !b;
            3'd5: return !a || !b;
            default: return 1'b0;
        endcase
    endfunction

    logic [7:0] ctrl [8];
    logic [7:0] exp_in;
    logic [7:0] inv_v;
    logic [7:0] v;

    task automatic upd_in();
        for (int n = 0; n < 8; n++)
            if (ctrl[n][2:0] != 3'd4) exp_in[n] = pad_in[n] ^ ctrl[n][7];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 8; n++) ctrl[n] = '0;
        exp_in = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin rd(8'(a), v); check("R1 reg", v, 8'h00); end
        rd(8'h13, v); check("R1 ctrl", v, 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out", pad_out, 8'h00);
        check("R1 pull/ttl", pull_en | ttl_sel, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // R2 control layout, bits 5:4 read 0; R3 exports
        wr(8'h12, 8'hFF);
        rd(8'h12, v); check("R2 ctrl bits", v, 8'hCF);
        check("R3 pull", pull_en, 8'h04);
        check("R3 ttl", ttl_sel, 8'h04);
        wr(8'h12, 8'h00);

        // R3 output inversion
        wr(8'h00, 8'hA5); wr(8'h01, 8'h3C); wr(8'h10, 8'h80);
        check("R3 pad_out", pad_out, 8'hA4);
        check("R3 pad_oe", pad_oe, 8'h3C);
        wr(8'h10, 8'h00);

        // R4 latency: pad change visible from third edge
        pad_in = 8'h01;
        cyc(2); rd(8'h02, v); check("R4 not yet", v, 8'h00);
        cyc(1); rd(8'h02, v); check("R4 latency", v, 8'h01);

        // R7 freeze while disabled, R8 no false edge on re-enable
        wr(8'h10, 8'h04);
        pad_in = 8'h00; cyc(4);
        rd(8'h02, v); check("R7 frozen", v, 8'h01);
        rd(8'h03, v); check("R7 no flag", v, 8'h00);
        pad_in = 8'h01; cyc(4);
        wr(8'h10, 8'h02); cyc(4);
        rd(8'h03, v); check("R8 no false edge", v, 8'h00);
        rd(8'h02, v); check("R8 in resumes", v, 8'h01);

        // R6 reserved code 6: no interrupt, input follows
        wr(8'h10, 8'h06);
        pad_in = 8'h00; cyc(4);
        rd(8'h03, v); check("R6 reserved no flag", v, 8'h00);
        rd(8'h02, v); check("R6 reserved in", v, 8'h00);
        wr(8'h10, 8'h00);

        // R9 level re-asserts, R10 partial clear
        wr(8'h11, 8'h05); wr(8'h12, 8'h02);
        pad_in = 8'h04; cyc(4);
        rd(8'h03, v); check("R5 level+rise", v, 8'h06);
        check("R10 irq", {7'd0, irq}, 8'h01);
        wr(8'h03, 8'h02);
        rd(8'h03, v); check("R9 level stays", v, 8'h06);
        wr(8'h03, 8'h04);
        rd(8'h03, v); check("R10 partial clear", v, 8'h02);
        pad_in = 8'h06; cyc(4);
        wr(8'h03, 8'h02);
        rd(8'h03, v); check("R10 clear", v, 8'h00);
        check("R10 irq low", {7'd0, irq}, 8'h00);
        wr(8'h11, 8'h00); wr(8'h12, 8'h00);
        ctrl[1] = '0; ctrl[2] = '0;
        cyc(4); upd_in();

        // Random: R4 R5 R6 R7 R3
        for (int it = 0; it < 60; it++) begin
            logic [7:0] oldp, newp, expf;
            for (int n = 0; n < 8; n++) begin
                ctrl[n] = 8'($urandom) & 8'hCF;
                if (ctrl[n][2:0] == 3'd7 && ($urandom % 2) == 0) ctrl[n][2:0] = 3'd5;
                wr(8'(16 + n), ctrl[n]);
                inv_v[n] = ctrl[n][7];
            end
            v = 8'($urandom); wr(8'h00, v);
            check("R3 rand pad_out", pad_out, v ^ inv_v);
            cyc(4); upd_in();
            oldp = pad_in;
            wr(8'h03, 8'hFF); cyc(1);
            newp = 8'($urandom);
            pad_in = newp; cyc(4); upd_in();
            for (int n = 0; n < 8; n++)
                expf[n] = exp_flag(ctrl[n][2:0], oldp[n] ^ inv_v[n], newp[n] ^ inv_v[n]);
            rd(8'h03, v); check("R5 rand flags", v, expf);
            rd(8'h02, v); check("R4 rand in", v, exp_in);
            check("R10 rand irq", {7'd0, irq}, {7'd0, |expf});
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule